// File: doc/BRIEF.md
# DMA Completion Response Queue with Interrupt Generation

This block sits at the completion side of a descriptor-driven DMA engine. Each time the data movers finish a descriptor, they present one completion on a valid/ready stream. The completion carries the byte count, eight error bits, an early-termination flag and the descriptor's interrupt-request bits. The block stores the byte count, error bits and early flag as one entry in a response queue.

Software drains the queue through a two-word read window. The byte count is at offset 0x00 and the status word is at offset 0x04. An entry leaves the queue only when its status word is read after its byte count. The same completion stream also decides whether the engine interrupt is raised, under a global enable. It also decides whether issue is halted on an error or an early stop.

A small control/status space sits beside the window. It holds the control bits, the latched interrupt, the queue empty/full flags and the fill level. Back-pressure is simple: `cmp_ready` is low exactly while the queue holds its full depth. A completion counts as accepted only on a cycle where `cmp_valid` and `cmp_ready` are both high. While the queue is full the producer must hold its completion.

Top module: `dma_resp_irq`

## Requirements
- R1: A completion accepted on a cycle with `cmp_valid` and `cmp_ready` both high becomes one queue entry. Entries leave in arrival order. Window offset 0x00 returns the byte count. Window offset 0x04 returns the status word, with the error bits in bits 7:0 and the early-termination flag in bit 8.
- R2: `cmp_ready` is low exactly while DEPTH entries are held (default DEPTH 8). A completion offered while it is low is not stored.
- R3: The head entry is removed on a status-word read, and only if a byte-count read of that entry came before it. A status-word read with no byte-count read before it returns the status and leaves the queue unchanged.
- R4: A window read while the queue is empty returns zero and changes no state.
- R5: CSR offset 0x0c returns the number of held entries in bits 15:0. In the status register (CSR 0x00), bit 3 is set when the queue is empty and bit 4 when it is full.
- R6: An accepted completion is an interrupt event when any of these holds:
  - its completion request (descriptor bit 14) is set;
  - its early request (bit 15) is set and the early flag is set;
  - its error bits AND its error mask (bits 23:16) are nonzero.
- R6 (continued): An event latches status bit 9 and drives `irq` high only when control bit 4 (global enable) is set.
- R7: Writing 1 to status bit 9 clears the latched interrupt. An event in the same cycle wins over the clear.
- R8: With control bit 2 set, an accepted completion with any error bit set latches status bit 7 and `stop_err`. With control bit 3 set, an accepted completion with the early flag latches status bit 8 and `stop_early`. Each is cleared by writing 1 to its status bit.
- R9: The control register (CSR 0x04) reads back bits 2, 3 and 4 as last written, and zero elsewhere.
- R10: After reset the queue is empty, the fill level is 0, `irq`, `stop_err` and `stop_early` are low, and `cmp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Completion offered |
| cmp_ready | output | 1 | Queue can take a completion |
| cmp_bytes | input | 32 | Bytes moved by the descriptor |
| cmp_err | input | 8 | Error bits of the completion |
| cmp_early | input | 1 | Descriptor ended early |
| cmp_irq_done | input | 1 | Descriptor requests an interrupt on completion |
| cmp_irq_early | input | 1 | Descriptor requests an interrupt on early end |
| cmp_err_mask | input | 8 | Error bits that raise an interrupt |
| csr_addr | input | 5 | CSR byte address |
| csr_wr | input | 1 | CSR write strobe |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational from address) |
| resp_rd | input | 1 | Response window read strobe |
| resp_addr | input | 4 | Response window byte address |
| resp_rdata | output | 32 | Response window read data |
| irq | output | 1 | Engine interrupt |
| stop_err | output | 1 | Halt issue: stopped on error |
| stop_early | output | 1 | Halt issue: stopped on early end |

## Verification
The assertions rely on three assumptions about this block's inputs:
- Window reads are made one per cycle, with the address steady for the cycle of the strobe.
- The completion fields are meaningful only while `cmp_valid` is high.
- A CSR write and a completion may coincide.

The stimulus drives every input on the falling edge and holds each read or write strobe for exactly one cycle. It offers a completion against a full queue only as a deliberate single-cycle attempt. It also applies a status clear in the same cycle as an interrupt event on purpose, so that the priority rule of R7 is reached.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

  parameter int unsigned BYTES_W = 32;
  parameter int unsigned ERR_W   = 8;
  parameter int unsigned DATA_W  = 32;

  typedef struct packed {
    logic [BYTES_W-1:0] bytes;
    logic [ERR_W-1:0]   err;
    logic               early;
  } rsp_entry_t;

  // CSR word indices (byte address bits 4:2)
  localparam logic [2:0] CSR_STATUS_IDX = 3'd0;
  localparam logic [2:0] CSR_CTRL_IDX   = 3'd1;
  localparam logic [2:0] CSR_FILL_IDX   = 3'd3;

  // status register bit positions
  localparam int unsigned ST_EMPTY      = 3;
  localparam int unsigned ST_FULL       = 4;
  localparam int unsigned ST_STOP_ERR   = 7;
  localparam int unsigned ST_STOP_EARLY = 8;
  localparam int unsigned ST_IRQ        = 9;

  // control register bit positions
  localparam int unsigned CT_STOP_ERR   = 2;
  localparam int unsigned CT_STOP_EARLY = 3;
  localparam int unsigned CT_GIE        = 4;

  // response status word
  localparam int unsigned SW_EARLY = 8;

endpackage

// File: rtl/rsp_fifo.sv
module rsp_fifo
  import rsp_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  rsp_entry_t       push_data,
  input  logic             pop,
  output rsp_entry_t       head,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);

  rsp_entry_t       store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2: the producer side never pushes into a full queue
  a_r2_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

  // R4: the read window never pops an empty queue
  a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);

  // R2: occupancy stays within depth
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

endmodule

// File: rtl/rsp_window.sv
module rsp_window
  import rsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              word_sel,
  input  logic              empty,
  input  rsp_entry_t        head,
  output logic [DATA_W-1:0] rdata,
  output logic              pop
);

  logic byte_seen;

  always_comb begin
    rdata = '0;
    pop   = 1'b0;
    if (rd && !empty) begin
      if (!word_sel) begin
        rdata[BYTES_W-1:0] = head.bytes;
      end else begin
        rdata[ERR_W-1:0] = head.err;
        rdata[SW_EARLY]  = head.early;
        pop              = byte_seen;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_seen <= 1'b0;
    end else if (rd && !empty) begin
      if (!word_sel)      byte_seen <= 1'b1;
      else if (byte_seen) byte_seen <= 1'b0;
    end
  end

  // R3: the pair flag is armed only by a byte-count read
  a_r3_armed_by_byte_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_seen) |-> $past(rd && !word_sel && !empty));

  // R4: empty reads return zero
  a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && empty) |-> (rdata == '0));

endmodule

// File: rtl/rsp_irq_ctrl.sv
module rsp_irq_ctrl
  import rsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ERR_W-1:0]  err,
  input  logic              early,
  input  logic              req_done,
  input  logic              req_early,
  input  logic [ERR_W-1:0]  err_mask,
  input  logic              ctl_wr,
  input  logic              sts_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl_q,
  output logic              irq_pend,
  output logic              stop_err,
  output logic              stop_early
);

  logic gie, stop_err_en, stop_early_en;
  logic evt;

  assign evt = accept && (req_done || (req_early && early) || (|(err & err_mask)));

  always_comb begin
    ctl_q                = '0;
    ctl_q[CT_STOP_ERR]   = stop_err_en;
    ctl_q[CT_STOP_EARLY] = stop_early_en;
    ctl_q[CT_GIE]        = gie;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie           <= 1'b0;
      stop_err_en   <= 1'b0;
      stop_early_en <= 1'b0;
    end else if (ctl_wr) begin
      gie           <= wdata[CT_GIE];
      stop_err_en   <= wdata[CT_STOP_ERR];
      stop_early_en <= wdata[CT_STOP_EARLY];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pend   <= 1'b0;
      stop_err   <= 1'b0;
      stop_early <= 1'b0;
    end else begin
      if (evt && gie)                   irq_pend <= 1'b1;
      else if (sts_wr && wdata[ST_IRQ]) irq_pend <= 1'b0;

      if (accept && stop_err_en && (|err))   stop_err <= 1'b1;
      else if (sts_wr && wdata[ST_STOP_ERR]) stop_err <= 1'b0;

      if (accept && stop_early_en && early)    stop_early <= 1'b1;
      else if (sts_wr && wdata[ST_STOP_EARLY]) stop_early <= 1'b0;
    end
  end

  // R6: interrupt latches only while globally enabled
  a_r6_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $past(gie && accept));

  // R7: a clear with no competing event drops the interrupt
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && wdata[ST_IRQ] && !evt) |=> !irq_pend);

  // R8: stop on error needs an accepted erroring completion
  a_r8_stop_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_err) |-> $past(accept && (|err)));

  // R8: stop on early end needs an accepted early completion
  a_r8_stop_early_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_early) |-> $past(accept && early));

endmodule

// File: rtl/dma_resp_irq.sv
module dma_resp_irq
  import rsp_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmp_valid,
  output logic        cmp_ready,
  input  logic [31:0] cmp_bytes,
  input  logic [7:0]  cmp_err,
  input  logic        cmp_early,
  input  logic        cmp_irq_done,
  input  logic        cmp_irq_early,
  input  logic [7:0]  cmp_err_mask,
  input  logic [4:0]  csr_addr,
  input  logic        csr_wr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic        resp_rd,
  input  logic [3:0]  resp_addr,
  output logic [31:0] resp_rdata,
  output logic        irq,
  output logic        stop_err,
  output logic        stop_early
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  rsp_entry_t       in_entry, head;
  logic [CNT_W-1:0] fill;
  logic             empty, full, accept, pop;
  logic             ctl_wr, sts_wr;
  logic [2:0]       csr_idx;
  logic [DATA_W-1:0] ctl_q;
  logic             unused_addr_bits;

  assign unused_addr_bits = ^{csr_addr[1:0], resp_addr[3], resp_addr[1:0]};

  assign cmp_ready      = !full;
  assign accept         = cmp_valid && cmp_ready;
  assign in_entry.bytes = cmp_bytes;
  assign in_entry.err   = cmp_err;
  assign in_entry.early = cmp_early;

  assign csr_idx = csr_addr[4:2];
  assign ctl_wr  = csr_wr && (csr_idx == CSR_CTRL_IDX);
  assign sts_wr  = csr_wr && (csr_idx == CSR_STATUS_IDX);

  rsp_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_data (in_entry),
    .pop       (pop),
    .head      (head),
    .count     (fill),
    .empty     (empty),
    .full      (full)
  );

  rsp_window u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (resp_rd),
    .word_sel (resp_addr[2]),
    .empty    (empty),
    .head     (head),
    .rdata    (resp_rdata),
    .pop      (pop)
  );

  rsp_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .err        (cmp_err),
    .early      (cmp_early),
    .req_done   (cmp_irq_done),
    .req_early  (cmp_irq_early),
    .err_mask   (cmp_err_mask),
    .ctl_wr     (ctl_wr),
    .sts_wr     (sts_wr),
    .wdata      (csr_wdata),
    .ctl_q      (ctl_q),
    .irq_pend   (irq),
    .stop_err   (stop_err),
    .stop_early (stop_early)
  );

  always_comb begin
    csr_rdata = '0;
    case (csr_idx)
      CSR_STATUS_IDX: begin
        csr_rdata[ST_EMPTY]      = empty;
        csr_rdata[ST_FULL]       = full;
        csr_rdata[ST_STOP_ERR]   = stop_err;
        csr_rdata[ST_STOP_EARLY] = stop_early;
        csr_rdata[ST_IRQ]        = irq;
      end
      CSR_CTRL_IDX: csr_rdata = ctl_q;
      CSR_FILL_IDX: csr_rdata[CNT_W-1:0] = fill;
      default: csr_rdata = '0;
    endcase
  end

  // R1: an accepted completion with no pop raises the fill level by one
  a_r1_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !pop) |=> (fill == $past(fill) + 1'b1));

  // R3: a status read without a pop leaves the fill level alone
  a_r3_status_no_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_rd && resp_addr[2] && !pop && !accept) |=> $stable(fill));

endmodule

// File: tb/test_dma_resp_irq.sv
`timescale 1ns/1ps
module test_dma_resp_irq;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp_valid, cmp_ready;
  logic [31:0] cmp_bytes;
  logic [7:0]  cmp_err, cmp_err_mask;
  logic        cmp_early, cmp_irq_done, cmp_irq_early;
  logic [4:0]  csr_addr;
  logic        csr_wr;
  logic [31:0] csr_wdata, csr_rdata;
  logic        resp_rd;
  logic [3:0]  resp_addr;
  logic [31:0] resp_rdata;
  logic        irq, stop_err, stop_early;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dma_resp_irq #(.DEPTH(DEPTH)) i_dma_resp_irq (
    .clk(clk), .rst_n(rst_n),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_bytes(cmp_bytes),
    .cmp_err(cmp_err), .cmp_early(cmp_early), .cmp_irq_done(cmp_irq_done),
    .cmp_irq_early(cmp_irq_early), .cmp_err_mask(cmp_err_mask),
    .csr_addr(csr_addr), .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .resp_rd(resp_rd), .resp_addr(resp_addr), .resp_rdata(resp_rdata),
    .irq(irq), .stop_err(stop_err), .stop_early(stop_early)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FIFO_CHECK FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] b, input logic [7:0] e, input logic early,
                      input logic rq_done, input logic rq_early, input logic [7:0] mask,
                      output logic took);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_bytes = b; cmp_err = e; cmp_early = early;
    cmp_irq_done = rq_done; cmp_irq_early = rq_early; cmp_err_mask = mask;
    #1 took = cmp_ready;
    @(negedge clk);
    cmp_valid = 1'b0; cmp_irq_done = 1'b0; cmp_irq_early = 1'b0; cmp_err_mask = '0;
  endtask

  task automatic resp_read(input logic status_word, output logic [31:0] d);
    @(negedge clk);
    resp_rd = 1'b1; resp_addr = status_word ? 4'h4 : 4'h0;
    #1 d = resp_rdata;
    @(negedge clk);
    resp_rd = 1'b0;
  endtask

  task automatic csr_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  task automatic csr_write(input logic [4:0] a, input logic [31:0] v);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = v;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic drain(input int n);
    logic [31:0] d;
    for (int i = 0; i < n; i++) begin
      resp_read(1'b0, d);
      resp_read(1'b1, d);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    csr_read(5'h0c, d); check("R10 fill after reset", d, 32'd0);
    csr_read(5'h00, d); check("R10 status after reset", d, 32'h8);
    check("R10 ready/irq/stops", {28'd0, cmp_ready, irq, stop_err, stop_early}, 32'h8);
    resp_read(1'b0, d); check("R4 empty byte read", d, 32'd0);
    resp_read(1'b1, d); check("R4 empty status read", d, 32'd0);
    csr_read(5'h0c, d); check("R4 fill unchanged", d, 32'd0);
  endtask

  task automatic t_order;
    logic took;
    logic [31:0] d;
    push(32'h0000_1000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, took);
    push(32'h0000_2222, 8'h5a, 1'b1, 1'b0, 1'b0, 8'h00, took);
    push(32'hdead_0003, 8'h81, 1'b0, 1'b0, 1'b0, 8'h00, took);
    csr_read(5'h0c, d); check("R5 fill after 3 pushes", d, 32'd3);
    csr_read(5'h00, d); check("R5 not empty", d & 32'h18, 32'h0);
    resp_read(1'b0, d); check("R1 entry0 bytes", d, 32'h0000_1000);
    resp_read(1'b1, d); check("R1 entry0 status", d, 32'h000);
    resp_read(1'b0, d); check("R1 entry1 bytes", d, 32'h0000_2222);
    resp_read(1'b1, d); check("R1 entry1 status", d, 32'h15a);
    csr_read(5'h0c, d); check("R3 fill after two pops", d, 32'd1);
    resp_read(1'b0, d); check("R1 entry2 bytes", d, 32'hdead_0003);
    resp_read(1'b1, d); check("R1 entry2 status", d, 32'h081);
    csr_read(5'h0c, d); check("R5 fill drained", d, 32'd0);
  endtask

  task automatic t_pair_rule;
    logic took;
    logic [31:0] d;
    push(32'd77, 8'h03, 1'b0, 1'b0, 1'b0, 8'h00, took);
    resp_read(1'b1, d); check("R3 lone status read data", d, 32'h003);
    csr_read(5'h0c, d); check("R3 lone status read keeps entry", d, 32'd1);
    resp_read(1'b0, d); check("R3 bytes read", d, 32'd77);
    csr_read(5'h0c, d); check("R3 bytes read does not pop", d, 32'd1);
    resp_read(1'b1, d); check("R3 paired status", d, 32'h003);
    csr_read(5'h0c, d); check("R3 pair pops", d, 32'd0);
  endtask

  task automatic t_full;
    logic took;
    logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) begin
      push(32'd100 + 32'(i), 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, took);
      check("R2 accepted below depth", {31'd0, took}, 32'd1);
    end
    check("R2 ready low when full", {31'd0, cmp_ready}, 32'd0);
    csr_read(5'h00, d); check("R5 full flag", d & 32'h18, 32'h10);
    csr_read(5'h0c, d); check("R5 fill at depth", d, 32'(DEPTH));
    push(32'd999, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, took);
    check("R2 blocked push", {31'd0, took}, 32'd0);
    for (int i = 0; i < DEPTH; i++) begin
      resp_read(1'b0, d); check("R2 drain order bytes", d, 32'd100 + 32'(i));
      resp_read(1'b1, d);
    end
    csr_read(5'h0c, d); check("R2 blocked entry not stored", d, 32'd0);
    check("R2 ready restored", {31'd0, cmp_ready}, 32'd1);
  endtask

  task automatic t_irq;
    logic took;
    logic [31:0] d;
    push(32'd1, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, took);
    check("R6 no irq without global enable", {31'd0, irq}, 32'd0);
    csr_write(5'h04, 32'h10);
    push(32'd2, 8'h00, 1'b0, 1'b0, 1'b0, 8'hff, took);
    check("R6 no request no irq", {31'd0, irq}, 32'd0);
    push(32'd3, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, took);
    check("R6 early request without early flag", {31'd0, irq}, 32'd0);
    push(32'd4, 8'h04, 1'b0, 1'b0, 1'b0, 8'h02, took);
    check("R6 unmasked error", {31'd0, irq}, 32'd0);
    push(32'd5, 8'h04, 1'b0, 1'b0, 1'b0, 8'h06, took);
    check("R6 masked error fires", {31'd0, irq}, 32'd1);
    csr_read(5'h00, d); check("R6 status bit 9", (d >> 9) & 32'd1, 32'd1);
    csr_write(5'h00, 32'h200);
    check("R7 clear", {31'd0, irq}, 32'd0);
    push(32'd6, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, took);
    check("R6 early end fires", {31'd0, irq}, 32'd1);
    csr_write(5'h00, 32'h200);
    push(32'd7, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, took);
    check("R6 completion request fires", {31'd0, irq}, 32'd1);
    csr_write(5'h00, 32'h200);
    drain(7);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_bytes = 32'd8; cmp_err = '0; cmp_early = 1'b0;
    cmp_irq_done = 1'b1; csr_wr = 1'b1; csr_addr = 5'h00; csr_wdata = 32'h200;
    @(negedge clk);
    cmp_valid = 1'b0; cmp_irq_done = 1'b0; csr_wr = 1'b0;
    check("R7 event wins over clear", {31'd0, irq}, 32'd1);
    csr_write(5'h00, 32'h200);
    check("R7 cleared afterwards", {31'd0, irq}, 32'd0);
    drain(1);
    csr_write(5'h04, 32'h0);
  endtask

  task automatic t_stop;
    logic took;
    logic [31:0] d;
    push(32'd9, 8'h01, 1'b0, 1'b0, 1'b0, 8'h00, took);
    check("R8 no stop when disabled", {31'd0, stop_err}, 32'd0);
    csr_write(5'h04, 32'h04);
    push(32'd10, 8'h01, 1'b0, 1'b0, 1'b0, 8'h00, took);
    check("R8 stop on error", {31'd0, stop_err}, 32'd1);
    csr_read(5'h00, d); check("R8 status bit 7", (d >> 7) & 32'd1, 32'd1);
    csr_write(5'h00, 32'h80);
    check("R8 stop error cleared", {31'd0, stop_err}, 32'd0);
    push(32'd11, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, took);
    check("R8 early ignored when disabled", {31'd0, stop_early}, 32'd0);
    csr_write(5'h04, 32'h08);
    push(32'd12, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, took);
    check("R8 stop on early", {31'd0, stop_early}, 32'd1);
    csr_read(5'h00, d); check("R8 status bit 8", (d >> 8) & 32'd1, 32'd1);
    csr_write(5'h00, 32'h100);
    check("R8 stop early cleared", {31'd0, stop_early}, 32'd0);
    drain(4);
    csr_write(5'h04, 32'h0);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    csr_write(5'h04, 32'hffff_ffff);
    csr_read(5'h04, d); check("R9 control readback", d, 32'h1c);
    csr_write(5'h04, 32'h0);
    csr_read(5'h04, d); check("R9 control cleared", d, 32'h0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("watchdog expired: FAIL R10 actual hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmp_valid = 1'b0; cmp_bytes = '0; cmp_err = '0; cmp_early = 1'b0;
    cmp_irq_done = 1'b0; cmp_irq_early = 1'b0; cmp_err_mask = '0;
    csr_addr = '0; csr_wr = 1'b0; csr_wdata = '0;
    resp_rd = 1'b0; resp_addr = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset;
    t_order;
    t_pair_rule;
    t_full;
    t_irq;
    t_stop;
    t_ctrl;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule